// File: doc/BRIEF.md
# Dual-Replica Read Scheduler

This block serves single-word reads from a page whose contents may be held twice, in two physical copies reached through two independent memory read channels. Every stored word carries one parity bit. The scheduler sends the read to the preferred copy first. The preferred copy is the one the requester reports as having fewer defective words. The scheduler then checks the parity of the returned word. A parity failure marks the word as defective, and the scheduler takes the data from the other copy instead. A pair of copies is built so that a defective word in one copy has a sound word at the same offset in the other.

A mode input chooses the fetch policy for each request. In lazy mode the copies are read one after the other, and the second copy is touched only when the first one fails. In eager mode both copies are requested together. This lowers the latency of a fallback but costs an extra access on every read. Pages that are not duplicated are read from channel A only and have no fallback. Only one request is in flight at a time. A saturating counter records how many reads needed the other copy.

Top module: `dual_replica_rd`

## Requirements
- R1: When a replicated request is accepted, copy B is primary only if its defect count is strictly lower than that of copy A; on a tie, A is primary. In lazy mode only the primary channel is requested in the cycle after acceptance.
- R2: A returned word has DATA_W data bits with the parity bit at bit DATA_W. The word passes when the total number of ones across all DATA_W+1 bits is even.
- R3: In lazy mode, when the primary word passes, the response carries its data with the error flag clear, and the other channel is never requested.
- R4: In lazy mode, when the primary word fails on a replicated page, exactly one read goes to the secondary channel after the primary returns. The response carries the secondary data.
- R5: In eager mode on a replicated page, both channels are requested in the cycle after acceptance. The response uses the primary data if it passes and the secondary data otherwise. The secondary read is always consumed, even when it is not used.
- R6: A non-replicated request reads channel A only, in either mode. If that word fails parity, the response returns its data with the error flag set.
- R7: If both copies of a word fail parity, the response carries the secondary data with the error flag set.
- R8: req_ready is low from acceptance until the response handshake is done and every channel read already issued has returned.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid stays high and rsp_data and rsp_uncorr do not change.
- R10: fallback_count rises by one for each replicated request whose primary word fails parity, in either mode. It stays at its all-ones maximum once reached.
- R11: After reset, req_ready is high, rsp_valid is low, neither channel is requested, and fallback_count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Scheduler can accept a request |
| req_addr_a | input | ADDR_W | Word address in copy A |
| req_addr_b | input | ADDR_W | Word address in copy B |
| req_defects_a | input | DEFECT_W | Defective-word count of copy A |
| req_defects_b | input | DEFECT_W | Defective-word count of copy B |
| req_replicated | input | 1 | Page has two copies |
| mode_eager | input | 1 | 1: read both copies at once; 0: sequential |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DATA_W | Returned data |
| rsp_uncorr | output | 1 | No copy passed parity |
| a_req_valid | output | 1 | Channel A read request |
| a_req_ready | input | 1 | Channel A accepts the request |
| a_req_addr | output | ADDR_W | Channel A read address |
| a_rsp_valid | input | 1 | Channel A returns a word |
| a_rsp_word | input | DATA_W+1 | Channel A word, parity in the top bit |
| b_req_valid | output | 1 | Channel B read request |
| b_req_ready | input | 1 | Channel B accepts the request |
| b_req_addr | output | ADDR_W | Channel B read address |
| b_rsp_valid | input | 1 | Channel B returns a word |
| b_rsp_word | input | DATA_W+1 | Channel B word, parity in the top bit |
| fallback_count | output | FB_CNT_W | Saturating count of reads served by the other copy |

## Verification
The bench builds the block with DATA_W=8, ADDR_W=10, DEFECT_W=6 and FB_CNT_W=3. The 3-bit counter tops out at 7, so a few dozen mixed reads drive fallback_count into saturation. Defect counts are drawn from a range of four values, so ties between the copies happen often and the tie rule toward copy A gets exercised. The channel models have a random latency of one to four cycles and random request backpressure. Together these let an eager secondary word arrive before the primary word or after the response, which shows that a late word is discarded and still holds off the next request.

// File: rtl/rdsched_pkg.sv
package rdsched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT_P = 2'd1,
    ST_WAIT_S = 2'd2,
    ST_RESP   = 2'd3
  } rd_state_e;

  localparam int NUM_COPIES = 2;
endpackage

// File: rtl/rdsched_parchk.sv
module rdsched_parchk #(
  parameter int WORD_W = 9
) (
  input  logic [WORD_W-1:0] word,
  output logic              ok
);
  // even parity over data plus parity bit
  assign ok = ~(^word);
endmodule

// File: rtl/rdsched_port.sv
module rdsched_port #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_word,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  logic outst;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      outst         <= 1'b0;
      done          <= 1'b0;
      word          <= '0;
    end else begin
      if (start) begin
        mem_req_valid <= 1'b1;
        mem_req_addr  <= start_addr;
        done          <= 1'b0;
      end else if (mem_req_valid && mem_req_ready) begin
        mem_req_valid <= 1'b0;
        outst         <= 1'b1;
      end
      if (outst && mem_rsp_valid) begin
        outst <= 1'b0;
        done  <= 1'b1;
        word  <= mem_rsp_word;
      end
    end
  end

  assign busy = mem_req_valid | outst;

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R8
  AST_RSP_ONLY_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> outst); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4
endmodule

// File: rtl/rdsched_fbcnt.sv
module rdsched_fbcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                          count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

  AST_FB_STEP: assert property (@(posedge clk) disable iff (rst)
    inc |=> (count == CNT_W'($past(count) + 1'b1)) || ($past(count) == CNT_MAX)); // R10
  AST_FB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count)); // R10
endmodule

// File: rtl/dual_replica_rd.sv
module dual_replica_rd #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 10,
  parameter int DEFECT_W = 6,
  parameter int FB_CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr_a,
  input  logic [ADDR_W-1:0]   req_addr_b,
  input  logic [DEFECT_W-1:0] req_defects_a,
  input  logic [DEFECT_W-1:0] req_defects_b,
  input  logic                req_replicated,
  input  logic                mode_eager,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                rsp_uncorr,
  output logic                a_req_valid,
  input  logic                a_req_ready,
  output logic [ADDR_W-1:0]   a_req_addr,
  input  logic                a_rsp_valid,
  input  logic [DATA_W:0]     a_rsp_word,
  output logic                b_req_valid,
  input  logic                b_req_ready,
  output logic [ADDR_W-1:0]   b_req_addr,
  input  logic                b_rsp_valid,
  input  logic [DATA_W:0]     b_rsp_word,
  output logic [FB_CNT_W-1:0] fallback_count
);
  import rdsched_pkg::*;
  localparam int WORD_W = DATA_W + 1;

  rd_state_e   state;
  logic        prim_sel, repl_q, eager_q;
  logic [ADDR_W-1:0] addr_q   [NUM_COPIES];
  logic [ADDR_W-1:0] addr_in  [NUM_COPIES];
  logic [ADDR_W-1:0] q_addr   [NUM_COPIES];
  logic [WORD_W-1:0] rsp_w    [NUM_COPIES];
  logic [WORD_W-1:0] word_q   [NUM_COPIES];
  logic [NUM_COPIES-1:0] q_ready, q_valid, r_valid, start, busy, done, ok;

  logic accept, prim_next, lazy_fetch, fb_inc;

  assign addr_in[0] = req_addr_a;
  assign addr_in[1] = req_addr_b;
  assign q_ready    = {b_req_ready, a_req_ready};
  assign r_valid    = {b_rsp_valid, a_rsp_valid};
  assign rsp_w[0]   = a_rsp_word;
  assign rsp_w[1]   = b_rsp_word;
  assign a_req_valid = q_valid[0];
  assign b_req_valid = q_valid[1];
  assign a_req_addr  = q_addr[0];
  assign b_req_addr  = q_addr[1];

  assign req_ready  = (state == ST_IDLE) && !(|busy);
  assign accept     = req_valid && req_ready;
  assign prim_next  = req_replicated && (req_defects_b < req_defects_a);
  assign lazy_fetch = (state == ST_WAIT_P) && done[prim_sel] && !ok[prim_sel]
                      && repl_q && !eager_q;
  assign fb_inc     = (state == ST_WAIT_P) && done[prim_sel] && !ok[prim_sel] && repl_q;

  for (genvar i = 0; i < NUM_COPIES; i++) begin : g_copy
    assign start[i] = (accept && ((prim_next == 1'(i)) || (req_replicated && mode_eager)))
                    || (lazy_fetch && (prim_sel != 1'(i)));

    rdsched_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_port (
      .clk          (clk),
      .rst          (rst),
      .start        (start[i]),
      .start_addr   (accept ? addr_in[i] : addr_q[i]),
      .mem_req_valid(q_valid[i]),
      .mem_req_ready(q_ready[i]),
      .mem_req_addr (q_addr[i]),
      .mem_rsp_valid(r_valid[i]),
      .mem_rsp_word (rsp_w[i]),
      .busy         (busy[i]),
      .done         (done[i]),
      .word         (word_q[i])
    );

    rdsched_parchk #(.WORD_W(WORD_W)) u_par (
      .word(word_q[i]),
      .ok  (ok[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      prim_sel   <= 1'b0;
      repl_q     <= 1'b0;
      eager_q    <= 1'b0;
      addr_q[0]  <= '0;
      addr_q[1]  <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_uncorr <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          prim_sel  <= prim_next;
          repl_q    <= req_replicated;
          eager_q   <= mode_eager;
          addr_q[0] <= req_addr_a;
          addr_q[1] <= req_addr_b;
          state     <= ST_WAIT_P;
        end
        ST_WAIT_P: if (done[prim_sel]) begin
          if (ok[prim_sel] || !repl_q) begin
            rsp_data   <= word_q[prim_sel][DATA_W-1:0];
            rsp_uncorr <= !ok[prim_sel];
            rsp_valid  <= 1'b1;
            state      <= ST_RESP;
          end else begin
            state <= ST_WAIT_S;
          end
        end
        ST_WAIT_S: if (done[!prim_sel]) begin
          rsp_data   <= word_q[!prim_sel][DATA_W-1:0];
          rsp_uncorr <= !ok[!prim_sel];
          rsp_valid  <= 1'b1;
          state      <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) begin
          rsp_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  rdsched_fbcnt #(.CNT_W(FB_CNT_W)) u_fbcnt (
    .clk  (clk),
    .rst  (rst),
    .inc  (fb_inc),
    .count(fallback_count)
  );

  AST_READY_EXCLUDES_RSP: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !rsp_valid); // R8
  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_uncorr)); // R9
  AST_LAZY_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    accept && !mode_eager |=> $countones({a_req_valid, b_req_valid}) == 1); // R1
  AST_EAGER_BOTH: assert property (@(posedge clk) disable iff (rst)
    accept && mode_eager && req_replicated |=> a_req_valid && b_req_valid); // R5
  AST_PLAIN_ONLY_A: assert property (@(posedge clk) disable iff (rst)
    accept && !req_replicated |=> a_req_valid && !b_req_valid); // R6
endmodule

// File: tb/dual_replica_rd_bench.sv
module dual_replica_rd_bench;
  localparam int DW = 8;
  localparam int AW = 10;
  localparam int DFW = 6;
  localparam int CW = 3;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_ready, req_rep = 1'b0, eager = 1'b0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [DFW-1:0] def_a = '0, def_b = '0;
  logic          rsp_valid, rsp_ready = 1'b0, rsp_unc;
  logic [DW-1:0] rsp_data;
  logic [CW-1:0] fb_cnt;
  logic          ch_qv [2];
  logic [AW-1:0] ch_qa [2];
  logic          ch_rdy [2];
  logic          ch_rv [2];
  logic [DW:0]   ch_rw [2];
  logic          bad_cur [2];
  int            acc [2];
  int tests = 0, fails = 0, fb_model = 0;

  dual_replica_rd #(.DATA_W(DW), .ADDR_W(AW), .DEFECT_W(DFW), .FB_CNT_W(CW)) u_dual_replica_rd (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr_a(addr_a), .req_addr_b(addr_b),
    .req_defects_a(def_a), .req_defects_b(def_b),
    .req_replicated(req_rep), .mode_eager(eager),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_uncorr(rsp_unc),
    .a_req_valid(ch_qv[0]), .a_req_ready(ch_rdy[0]), .a_req_addr(ch_qa[0]),
    .a_rsp_valid(ch_rv[0]), .a_rsp_word(ch_rw[0]),
    .b_req_valid(ch_qv[1]), .b_req_ready(ch_rdy[1]), .b_req_addr(ch_qa[1]),
    .b_rsp_valid(ch_rv[1]), .b_rsp_word(ch_rw[1]),
    .fallback_count(fb_cnt)
  );

  function automatic logic [DW-1:0] memdata(input int ch, input logic [AW-1:0] a);
    return DW'((int'(a) * 29) + (ch * 101) + 17);
  endfunction

  task automatic chk(input bit good, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_mem(input int ch);
    int cnt = 0;
    bit took;
    logic [AW-1:0] la = '0;
    logic [DW-1:0] d;
    forever begin
      @(posedge clk);
      took = ch_qv[ch] && ch_rdy[ch];
      if (took) la = ch_qa[ch];
      @(negedge clk);
      ch_rv[ch] = 1'b0;
      if (took) begin
        cnt = 1 + int'($urandom % 4);
        acc[ch]++;
      end
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          d = memdata(ch, la);
          ch_rv[ch] = 1'b1;
          ch_rw[ch] = {(^d) ^ bad_cur[ch], d};
        end
      end
      ch_rdy[ch] = ($urandom % 3) != 0;
    end
  endtask

  task automatic do_read(input logic [AW-1:0] aa, input logic [AW-1:0] ab,
                         input logic [DFW-1:0] da, input logic [DFW-1:0] db,
                         input bit rep, input bit eg, input bit ba, input bit bb);
    int prim, sec, hold, a0, a1, e0, e1;
    bit pbad, sbad, eunc;
    logic [DW-1:0] ed, held;
    logic [AW-1:0] pa, sa;
    string tag, utag;
    prim = (rep && (db < da)) ? 1 : 0;
    sec  = 1 - prim;
    pa   = prim ? ab : aa;
    sa   = prim ? aa : ab;
    pbad = prim ? bb : ba;
    sbad = prim ? ba : bb;
    if (!pbad)     begin ed = memdata(prim, pa); eunc = 1'b0; end
    else if (!rep) begin ed = memdata(prim, pa); eunc = 1'b1; end
    else           begin ed = memdata(sec, sa);  eunc = sbad; end
    if (rep && pbad && fb_model < CMAX) fb_model++;
    if (!rep) tag = "R6";
    else if (pbad && sbad) tag = "R7";
    else if (eg) tag = "R5";
    else if (pbad) tag = "R4";
    else tag = "R3";
    utag = (rep && pbad && sbad) ? "R7" : (!rep ? "R6" : "R2");
    e0 = (prim == 0) ? 1 : ((rep && (eg || pbad)) ? 1 : 0);
    e1 = (prim == 1) ? 1 : ((rep && (eg || pbad)) ? 1 : 0);

    bad_cur[0] = ba;
    bad_cur[1] = bb;
    while (!req_ready) @(negedge clk);
    a0 = acc[0];
    a1 = acc[1];
    addr_a = aa; addr_b = ab; def_a = da; def_b = db; req_rep = rep; eager = eg;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "ready after accept", req_ready, 0);
    chk(ch_qv[0] == ((prim == 0) || (rep && eg)), eg ? "R5" : "R1", "chan A request",
        ch_qv[0], (prim == 0) || (rep && eg));
    chk(ch_qv[1] == ((prim == 1) || (rep && eg)), eg ? "R5" : "R1", "chan B request",
        ch_qv[1], (prim == 1) || (rep && eg));
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    hold = int'($urandom % 3);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(rsp_valid && rsp_data == held, "R9", "held response", rsp_data, held);
    end
    chk(rsp_data == ed, tag, "response data", rsp_data, ed);
    chk(rsp_unc == eunc, utag, "error flag", rsp_unc, eunc);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    while (!req_ready) @(negedge clk);
    chk(fb_cnt == CW'(fb_model), "R10", "fallback count", fb_cnt, fb_model);
    chk(acc[0] - a0 == e0, tag, "chan A accesses", acc[0] - a0, e0);
    chk(acc[1] - a1 == e1, tag, "chan B accesses", acc[1] - a1, e1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) begin
      ch_rdy[i] = 1'b0; ch_rv[i] = 1'b0; ch_rw[i] = '0; bad_cur[i] = 1'b0; acc[i] = 0;
    end
    fork
      run_mem(0);
      run_mem(1);
    join_none
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", rsp_valid, 0);
    chk(!ch_qv[0] && !ch_qv[1], "R11", "channels idle", ch_qv[0] | ch_qv[1], 0);
    chk(fb_cnt == '0, "R11", "count after reset", fb_cnt, 0);

    // directed corners
    do_read(10'd5,  10'd900, 6'd3, 6'd3, 1, 0, 0, 0); // R1 tie -> A, R3 clean
    do_read(10'd6,  10'd901, 6'd4, 6'd1, 1, 0, 0, 0); // R1 B primary
    do_read(10'd7,  10'd902, 6'd2, 6'd5, 1, 0, 1, 0); // R4 lazy fallback to B
    do_read(10'd8,  10'd903, 6'd9, 6'd0, 1, 0, 0, 1); // R4 lazy fallback to A
    do_read(10'd9,  10'd904, 6'd0, 6'd0, 1, 1, 0, 0); // R5 eager clean
    do_read(10'd10, 10'd905, 6'd0, 6'd1, 1, 1, 1, 0); // R5 eager fallback
    do_read(10'd11, 10'd906, 6'd1, 6'd1, 1, 0, 1, 1); // R7 lazy both bad
    do_read(10'd12, 10'd907, 6'd1, 6'd1, 1, 1, 1, 1); // R7 eager both bad
    do_read(10'd13, 10'd908, 6'd7, 6'd0, 0, 0, 1, 0); // R6 plain, bad
    do_read(10'd14, 10'd909, 6'd7, 6'd0, 0, 1, 0, 1); // R6 plain eager, B ignored

    for (int n = 0; n < 60; n++) begin
      do_read(AW'($urandom), AW'($urandom), DFW'($urandom % 4), DFW'($urandom % 4),
              ($urandom % 4) != 0, $urandom % 2, ($urandom % 3) == 0, ($urandom % 4) == 0);
    end
    // R10 saturation: force several more fallbacks
    for (int n = 0; n < 8; n++) do_read(AW'(n), AW'(n + 40), 6'd0, 6'd0, 1, n % 2, 1, 0);
    chk(fb_cnt == CW'(CMAX), "R10", "saturated count", fb_cnt, CMAX);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule